// File: doc/BRIEF.md
# Banked System Register Access Controller

This block serves coprocessor move requests, reads and writes, aimed at one fixed system register encoding. A request that carries that encoding is checked against the current exception level, the hypervisor trap controls, the secure-state bit and the two secure-write disable lines. The request then completes normally, is refused as undefined, or is trapped to the hypervisor with a fixed syndrome code. A request with any other encoding is left alone and gets no response from this block.

The register exists as four 32-bit copies held inside the block. They form two banks, secure and non-secure, and each bank has two formats: a primary remap format and an extended attribute format. The format-select input picks the format. The bank is chosen by security state only when the request comes from exception level 3. A completed read returns the selected copy, and a completed write updates that copy alone.

A response appears on the outputs exactly one clock after the request strobe. It carries a one-hot result, the index of the copy that was used, a flag telling whether security banking was in effect, the trap kind and the syndrome.

Top module: `sysreg_bank_ctl`

## Requirements
- R1: A request gets a response only when its encoding is coprocessor 15, opc1 0, CRn 10, CRm 2, opc2 0. Any other encoding leaves rsp_valid low and writes nothing.
- R2: For every matching request, rsp_valid is high in the cycle after the strobe, and exactly one of rsp_ok, rsp_undef and rsp_trap is high in that cycle. All three are low whenever rsp_valid is low.
- R3: Every request from exception level 0 (cur_level = 0) is undefined, for reads and writes alike.
- R4: At level 1 with lvl2_enabled high, the checks run in a fixed order. grp_trap is checked first. After it comes vm_rd_trap for a read, or vm_wr_trap for a write. The first set bit gives rsp_trap, with rsp_syndrome = 0x03. Trap bits have no effect when lvl2_enabled is low, and they are never checked at level 2.
- R5: On a trap, rsp_trap_wide equals lvl2_wide: 1 selects the 64-bit-state trap kind, 0 selects the 32-bit hypervisor trap. rsp_trap_wide is 0 on any result other than a trap.
- R6: At levels 1 and 2, a completed access uses the non-secure bank, so rsp_copy[1] = 0. rsp_banked is high only when lvl3_present and lvl3_narrow are both high. Otherwise the access goes to the unbanked copy, which shares storage with the non-secure slot.
- R7: At level 3, sec_ns = 0 selects the secure bank and sec_ns = 1 selects the non-secure bank. rsp_copy[1] = 1 marks the secure bank, and rsp_banked is 1.
- R8: At level 3, a write with sec_ns = 0 is undefined when sec_dis_a or sec_dis_b is high. Reads under the same conditions complete, and so do non-secure writes.
- R9: rsp_copy[0] equals ext_fmt on a completed access: 1 selects the extended attribute copy and 0 selects the primary remap copy. rsp_copy and rsp_banked are 0 on any result other than ok.
- R10: All four copies reset to zero. A completed write updates only the copy named by rsp_copy. A trapped or undefined write changes no copy. A completed read returns the selected copy on rsp_rdata, and rsp_rdata is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write (move to register), 0 = read |
| req_cp | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| cur_level | input | 2 | Current exception level, 0 to 3 |
| lvl2_enabled | input | 1 | Level 2 is enabled |
| lvl2_wide | input | 1 | Level 2 runs in 64-bit state |
| lvl3_present | input | 1 | Level 3 is implemented |
| lvl3_narrow | input | 1 | Level 3 runs in 32-bit state |
| grp_trap | input | 1 | Hypervisor trap bit for this register group |
| vm_rd_trap | input | 1 | Hypervisor trap on reads of memory-control registers |
| vm_wr_trap | input | 1 | Hypervisor trap on writes of memory-control registers |
| sec_ns | input | 1 | Security state at level 3: 0 secure, 1 non-secure |
| sec_dis_a | input | 1 | First secure-write disable line |
| sec_dis_b | input | 1 | Second secure-write disable line |
| ext_fmt | input | 1 | Format select: 1 extended attribute, 0 primary remap |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access completed |
| rsp_undef | output | 1 | Access undefined |
| rsp_trap | output | 1 | Access trapped to level 2 |
| rsp_trap_wide | output | 1 | Trap kind: 1 for 64-bit state, 0 for 32-bit hypervisor |
| rsp_syndrome | output | 6 | Trap syndrome code, 0 when there is no trap |
| rsp_copy | output | 2 | Copy used: {secure bank, extended format} |
| rsp_banked | output | 1 | Bank was chosen by security banking |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: 32-bit copies, a 6-bit syndrome carrying code 0x03, and the single matching encoding. With these values every path of the priority chain can be reached from the ports. This covers the level 0 refusal, the group trap taking precedence over the read and write memory-control traps, the trap bits being ignored when level 2 is disabled, and the secure-write block at level 3. It also includes reads of all four copies after distinct writes, so that a write landing in the wrong bank or format shows up as a wrong read value. Near-miss encodings, each differing from the match in one field, confirm that the block stays silent for them.

// File: rtl/sysreg_bank_pkg.sv
package sysreg_bank_pkg;

    localparam int NUM_COPIES = 4;
    localparam int COPY_W     = $clog2(NUM_COPIES);

    typedef enum logic [2:0] {
        RES_NONE  = 3'b000,
        RES_OK    = 3'b001,
        RES_UNDEF = 3'b010,
        RES_TRAP  = 3'b100
    } res_e;

    typedef struct packed {
        logic [1:0] level;
        logic       l2_en;
        logic       l2_wide;
        logic       l3_present;
        logic       l3_narrow;
        logic       grp_trap;
        logic       vm_rd_trap;
        logic       vm_wr_trap;
        logic       sec_ns;
        logic       sec_dis_a;
        logic       sec_dis_b;
        logic       ext_fmt;
    } ctl_t;

    typedef struct packed {
        res_e              res;
        logic [COPY_W-1:0] copy;
        logic              banked;
        logic              trap_wide;
    } route_t;

    // Copy index layout: bit 1 = secure bank, bit 0 = extended format.
    function automatic logic [COPY_W-1:0] copy_idx(input logic secure, input logic ext);
        return {secure, ext};
    endfunction

endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match #(
    parameter logic [3:0] M_CP   = 4'd15,
    parameter logic [2:0] M_OPC1 = 3'd0,
    parameter logic [3:0] M_CRN  = 4'd10,
    parameter logic [3:0] M_CRM  = 4'd2,
    parameter logic [2:0] M_OPC2 = 3'd0
) (
    input  logic       valid,
    input  logic [3:0] cp,
    input  logic [2:0] opc1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] opc2,
    output logic       hit
);
    always_comb begin
        hit = valid && (cp == M_CP) && (opc1 == M_OPC1) && (crn == M_CRN)
                    && (crm == M_CRM) && (opc2 == M_OPC2);
    end
endmodule

// File: rtl/sysreg_route.sv
module sysreg_route
    import sysreg_bank_pkg::*;
(
    input  logic   is_write,
    input  ctl_t   ctl,
    output route_t route
);
    logic secure;
    logic banked;
    res_e res;

    always_comb begin
        res    = RES_OK;
        secure = 1'b0;
        banked = 1'b0;
        unique case (ctl.level)
            2'd0: res = RES_UNDEF;
            2'd1: begin
                banked = ctl.l3_present && ctl.l3_narrow;
                if (ctl.l2_en && ctl.grp_trap)
                    res = RES_TRAP;
                else if (ctl.l2_en && (is_write ? ctl.vm_wr_trap : ctl.vm_rd_trap))
                    res = RES_TRAP;
            end
            2'd2: banked = ctl.l3_present && ctl.l3_narrow;
            default: begin
                banked = 1'b1;
                secure = !ctl.sec_ns;
                if (is_write && !ctl.sec_ns && (ctl.sec_dis_a || ctl.sec_dis_b))
                    res = RES_UNDEF;
            end
        endcase

        route.res       = res;
        route.copy      = (res == RES_OK) ? copy_idx(secure, ctl.ext_fmt) : '0;
        route.banked    = (res == RES_OK) && banked;
        route.trap_wide = (res == RES_TRAP) && ctl.l2_wide;
    end
endmodule

// File: rtl/sysreg_copies.sv
module sysreg_copies
    import sysreg_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [COPY_W-1:0] sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [NUM_COPIES];

    for (genvar i = 0; i < NUM_COPIES; i++) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst)
                store[i] <= '0;
            else if (we && (sel == COPY_W'(i)))
                store[i] <= wdata;
        end

        // R10: a copy not addressed by a write keeps its value
        p_copy_hold_r10: assert property (@(posedge clk) disable iff (rst)
            !(we && (sel == COPY_W'(i))) |=> $stable(store[i]))
            else $error("copy %0d changed without a write", i);
    end

    always_comb rdata = store[sel];
endmodule

// File: rtl/sysreg_bank_ctl.sv
module sysreg_bank_ctl
    import sysreg_bank_pkg::*;
#(
    parameter int         DATA_W    = 32,
    parameter int         SYND_W    = 6,
    parameter logic [5:0] TRAP_CODE = 6'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_cp,
    input  logic [2:0]        req_opc1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_opc2,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cur_level,
    input  logic              lvl2_enabled,
    input  logic              lvl2_wide,
    input  logic              lvl3_present,
    input  logic              lvl3_narrow,
    input  logic              grp_trap,
    input  logic              vm_rd_trap,
    input  logic              vm_wr_trap,
    input  logic              sec_ns,
    input  logic              sec_dis_a,
    input  logic              sec_dis_b,
    input  logic              ext_fmt,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic              rsp_trap_wide,
    output logic [SYND_W-1:0] rsp_syndrome,
    output logic [1:0]        rsp_copy,
    output logic              rsp_banked,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              hit;
    ctl_t              ctl;
    route_t            route;
    logic              store_we;
    logic [DATA_W-1:0] store_rd;
    res_e              res_q;

    always_comb begin
        ctl.level      = cur_level;
        ctl.l2_en      = lvl2_enabled;
        ctl.l2_wide    = lvl2_wide;
        ctl.l3_present = lvl3_present;
        ctl.l3_narrow  = lvl3_narrow;
        ctl.grp_trap   = grp_trap;
        ctl.vm_rd_trap = vm_rd_trap;
        ctl.vm_wr_trap = vm_wr_trap;
        ctl.sec_ns     = sec_ns;
        ctl.sec_dis_a  = sec_dis_a;
        ctl.sec_dis_b  = sec_dis_b;
        ctl.ext_fmt    = ext_fmt;
    end

    sysreg_enc_match u_match (
        .valid (req_valid),
        .cp    (req_cp),
        .opc1  (req_opc1),
        .crn   (req_crn),
        .crm   (req_crm),
        .opc2  (req_opc2),
        .hit   (hit)
    );

    sysreg_route u_route (
        .is_write (req_write),
        .ctl      (ctl),
        .route    (route)
    );

    assign store_we = hit && req_write && (route.res == RES_OK);

    sysreg_copies #(.DATA_W(DATA_W)) u_copies (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .sel   (route.copy),
        .wdata (req_wdata),
        .rdata (store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst || !hit) begin
            rsp_valid     <= 1'b0;
            res_q         <= RES_NONE;
            rsp_trap_wide <= 1'b0;
            rsp_syndrome  <= '0;
            rsp_copy      <= '0;
            rsp_banked    <= 1'b0;
            rsp_rdata     <= '0;
        end else begin
            rsp_valid     <= 1'b1;
            res_q         <= route.res;
            rsp_trap_wide <= route.trap_wide;
            rsp_syndrome  <= (route.res == RES_TRAP) ? SYND_W'(TRAP_CODE) : '0;
            rsp_copy      <= route.copy;
            rsp_banked    <= route.banked;
            rsp_rdata     <= ((route.res == RES_OK) && !req_write) ? store_rd : '0;
        end
    end

    assign rsp_ok    = res_q[0];
    assign rsp_undef = res_q[1];
    assign rsp_trap  = res_q[2];

    // R1: foreign encodings get no response
    p_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit) |=> !rsp_valid);
    // R2: one result per response, none when idle
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_trap, rsp_undef, rsp_ok}) == 1));
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> ($countones({rsp_trap, rsp_undef, rsp_ok}) == 0));
    // R3: level 0 is always refused
    p_lvl0_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && cur_level == 2'd0) |=> rsp_undef);
    // R4: trap carries the fixed syndrome
    p_code_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_syndrome == SYND_W'(TRAP_CODE)));
    // R7: level 3 bank follows the security state
    p_lvl3bank_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && cur_level == 2'd3 && !req_write) |=> (rsp_ok && rsp_copy[1] == !$past(sec_ns)));
    // R8: secure write blocked by either disable line
    p_secblk_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && req_write && cur_level == 2'd3 && !sec_ns && (sec_dis_a || sec_dis_b))
        |=> rsp_undef);
endmodule

// File: tb/tb_sysreg_bank_ctl.sv
module tb_sysreg_bank_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [3:0]  req_cp, req_crn, req_crm;
    logic [2:0]  req_opc1, req_opc2;
    logic [31:0] req_wdata;
    logic [1:0]  cur_level;
    logic        lvl2_enabled, lvl2_wide, lvl3_present, lvl3_narrow;
    logic        grp_trap, vm_rd_trap, vm_wr_trap, sec_ns, sec_dis_a, sec_dis_b, ext_fmt;
    logic        rsp_valid, rsp_ok, rsp_undef, rsp_trap, rsp_trap_wide, rsp_banked;
    logic [5:0]  rsp_syndrome;
    logic [1:0]  rsp_copy;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    sysreg_bank_ctl dut (.*);

    typedef struct packed {
        logic       wr;
        logic [1:0] lvl;
        logic       l2en, l2w, l3p, l3n, grp, vmr, vmw, ns, da, db, fmt;
        logic [2:0] res;   // {trap, undef, ok}
        logic [1:0] cp;
        logic       bk;
        logic       wide;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // wr lvl  l2en l2w l3p l3n grp vmr vmw ns da db fmt   res    cp  bk wide
        '{1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'b010,2'd0,1'b0,1'b0}, // R3 read
        '{1'b1,2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b010,2'd0,1'b0,1'b0}, // R3 write
        '{1'b0,2'd1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'b100,2'd0,1'b0,1'b1}, // R4 R5 group trap
        '{1'b0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'b100,2'd0,1'b0,1'b0}, // R4 R5 hyp kind
        '{1'b0,2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'b100,2'd0,1'b0,1'b1}, // R4 read trap
        '{1'b0,2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,3'b001,2'd0,1'b0,1'b0}, // R4 write bit ignored on read
        '{1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,3'b100,2'd0,1'b0,1'b0}, // R4 write trap
        '{1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,3'b001,2'd1,1'b0,1'b0}, // R4 R9 read bit ignored on write
        '{1'b0,2'd1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,3'b001,2'd0,1'b1,1'b0}, // R4 R6 level 2 disabled
        '{1'b0,2'd2,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,3'b001,2'd0,1'b0,1'b0}, // R4 R6 level 2 no traps
        '{1'b1,2'd2,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,3'b001,2'd1,1'b1,1'b0}, // R6 R9 banked
        '{1'b0,2'd3,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'b001,2'd2,1'b1,1'b0}, // R7 secure
        '{1'b0,2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,3'b001,2'd1,1'b1,1'b0}, // R7 R9 non-secure
        '{1'b1,2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'b010,2'd0,1'b0,1'b0}, // R8 line a
        '{1'b1,2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,3'b010,2'd0,1'b0,1'b0}, // R8 line b
        '{1'b0,2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,3'b001,2'd3,1'b1,1'b0}, // R8 read allowed
        '{1'b1,2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,3'b001,2'd0,1'b1,1'b0}, // R8 non-secure write
        '{1'b1,2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b001,2'd3,1'b1,1'b0}  // R7 R9 secure ext write
    };

    task automatic check(input logic good, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_ctl(input vec_t v);
        req_write = v.wr;  cur_level = v.lvl;
        lvl2_enabled = v.l2en; lvl2_wide = v.l2w; lvl3_present = v.l3p; lvl3_narrow = v.l3n;
        grp_trap = v.grp; vm_rd_trap = v.vmr; vm_wr_trap = v.vmw;
        sec_ns = v.ns; sec_dis_a = v.da; sec_dis_b = v.db; ext_fmt = v.fmt;
    endtask

    task automatic set_enc(input logic [3:0] cp, input logic [2:0] o1, input logic [3:0] n,
                           input logic [3:0] m, input logic [2:0] o2);
        req_cp = cp; req_opc1 = o1; req_crn = n; req_crm = m; req_opc2 = o2;
    endtask

    // Drive one request at a falling edge; the response is sampled at the next falling edge.
    task automatic issue(input vec_t v, input logic [31:0] wd);
        @(negedge clk);
        set_ctl(v);
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic vec_t lvl3_acc(input logic wr, input logic ns, input logic fmt,
                                      input logic da);
        vec_t v = '0;
        v.wr = wr; v.lvl = 2'd3; v.l3p = 1'b1; v.l3n = 1'b1;
        v.ns = ns; v.fmt = fmt; v.da = da;
        return v;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pat [4];
        vec_t v;
        pat[0] = 32'h1111_a0a0; pat[1] = 32'h2222_b1b1;
        pat[2] = 32'h3333_c2c2; pat[3] = 32'h4444_d3d3;
        req_valid = 1'b0; req_wdata = '0;
        set_ctl('0);
        set_enc(4'd15, 3'd0, 4'd10, 4'd2, 3'd0);
        do_reset();

        // R2: idle after reset
        check(rsp_valid == 1'b0, "R2", "reset rsp_valid", rsp_valid, 0);
        check({rsp_trap, rsp_undef, rsp_ok} == 3'b000, "R2", "reset result",
              {rsp_trap, rsp_undef, rsp_ok}, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i], 32'hdead_0000 + i);
            check(rsp_valid == 1'b1, "R2", $sformatf("vec %0d valid", i), rsp_valid, 1);
            check({rsp_trap, rsp_undef, rsp_ok} == VECS[i].res, "R3/R4/R8",
                  $sformatf("vec %0d result", i), {rsp_trap, rsp_undef, rsp_ok}, VECS[i].res);
            check(rsp_copy == VECS[i].cp, "R6/R7/R9", $sformatf("vec %0d copy", i),
                  rsp_copy, VECS[i].cp);
            check(rsp_banked == VECS[i].bk, "R6", $sformatf("vec %0d banked", i),
                  rsp_banked, VECS[i].bk);
            check(rsp_trap_wide == VECS[i].wide, "R5", $sformatf("vec %0d kind", i),
                  rsp_trap_wide, VECS[i].wide);
            check(rsp_syndrome == (VECS[i].res[2] ? 6'h03 : 6'h00), "R4",
                  $sformatf("vec %0d syndrome", i), rsp_syndrome, VECS[i].res[2] ? 3 : 0);
            // R2: response lasts one cycle
            @(negedge clk);
            check(rsp_valid == 1'b0, "R2", $sformatf("vec %0d one cycle", i), rsp_valid, 0);
        end

        // R10: all copies zero after reset
        do_reset();
        for (int c = 0; c < 4; c++) begin
            issue(lvl3_acc(1'b0, !c[1], c[0], 1'b0), '0);
            check(rsp_ok && rsp_rdata == 32'h0, "R10", $sformatf("reset copy %0d", c), rsp_rdata, 0);
        end

        // R10 R7 R9: each write goes to its own copy
        for (int c = 0; c < 4; c++) issue(lvl3_acc(1'b1, !c[1], c[0], 1'b0), pat[c]);
        for (int c = 0; c < 4; c++) begin
            issue(lvl3_acc(1'b0, !c[1], c[0], 1'b0), '0);
            check(rsp_rdata == pat[c], "R10", $sformatf("readback copy %0d", c), rsp_rdata, pat[c]);
        end

        // R10: write response carries no data
        issue(lvl3_acc(1'b1, 1'b1, 1'b0, 1'b0), pat[0]);
        check(rsp_ok && rsp_rdata == 32'h0, "R10", "write rdata", rsp_rdata, 0);

        // R8 R10: blocked secure write leaves the secure copy unchanged
        issue(lvl3_acc(1'b1, 1'b0, 1'b0, 1'b1), 32'hbad0_bad0);
        check(rsp_undef == 1'b1, "R8", "blocked write", rsp_undef, 1);
        issue(lvl3_acc(1'b0, 1'b0, 1'b0, 1'b1), '0);
        check(rsp_ok && rsp_rdata == pat[2], "R8", "secure copy kept", rsp_rdata, pat[2]);

        // R6: level 1 read with a 32-bit level 3 reads the non-secure extended copy
        v = '0; v.lvl = 2'd1; v.l3p = 1'b1; v.l3n = 1'b1; v.fmt = 1'b1;
        issue(v, '0);
        check(rsp_ok && rsp_rdata == pat[1], "R6", "level 1 non-secure read", rsp_rdata, pat[1]);

        // R4 R10: trapped write changes nothing
        v = '0; v.wr = 1'b1; v.lvl = 2'd1; v.l2en = 1'b1; v.grp = 1'b1;
        issue(v, 32'hbad1_bad1);
        check(rsp_trap == 1'b1, "R4", "trapped write", rsp_trap, 1);
        issue(lvl3_acc(1'b0, 1'b1, 1'b0, 1'b0), '0);
        check(rsp_rdata == pat[0], "R10", "copy kept after trap", rsp_rdata, pat[0]);

        // R3 R10: level 0 write changes nothing
        v = '0; v.wr = 1'b1; v.fmt = 1'b1;
        issue(v, 32'hbad2_bad2);
        issue(lvl3_acc(1'b0, 1'b1, 1'b1, 1'b0), '0);
        check(rsp_rdata == pat[1], "R3", "copy kept after level 0 write", rsp_rdata, pat[1]);

        // R1: near-miss encodings are silent and write nothing
        for (int k = 0; k < 5; k++) begin
            unique case (k)
                0: set_enc(4'd14, 3'd0, 4'd10, 4'd2, 3'd0);
                1: set_enc(4'd15, 3'd1, 4'd10, 4'd2, 3'd0);
                2: set_enc(4'd15, 3'd0, 4'd11, 4'd2, 3'd0);
                3: set_enc(4'd15, 3'd0, 4'd10, 4'd3, 3'd0);
                default: set_enc(4'd15, 3'd0, 4'd10, 4'd2, 3'd1);
            endcase
            issue(lvl3_acc(1'b1, 1'b1, 1'b0, 1'b0), 32'hbad3_0000 + k);
            check(rsp_valid == 1'b0, "R1", $sformatf("miss %0d silent", k), rsp_valid, 0);
        end
        set_enc(4'd15, 3'd0, 4'd10, 4'd2, 3'd0);
        issue(lvl3_acc(1'b0, 1'b1, 1'b0, 1'b0), '0);
        check(rsp_rdata == pat[0], "R1", "copy kept after misses", rsp_rdata, pat[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule